// File: doc/BRIEF.md
# Seed Challenge Responder

This block answers a host's authentication challenge over a byte stream. The host sends single bytes with a valid strobe. The block waits for a lead byte. One lead byte opens a seed message of fixed length. The message carries ten 16-bit seeds. The block adds up two selected subsets of those seeds and turns each sum into four reply bytes. Because every unit has its own configuration word, the same challenge gives a different answer on each unit.

Once the seeds are in, the host sends the unit's acknowledge byte. Each acknowledge produces a nine-byte reply on a valid/ready output stream: a fixed header byte followed by the eight derived bytes. The engine answers two acknowledges per seed message and then returns to idle. A second lead byte opens a text path message. The block swallows that message up to its line-feed terminator and sends no reply. Serial framing is done by an external UART; this block sees whole bytes only.

Top module: `seed_resp`

## Requirements
- R1: After reset the output stream is idle (out_valid low), and the engine is idle: an acknowledge byte sent before any seed message gives no reply.
- R2: In idle, byte 0x56 starts seed collection and byte 0x44 starts path collection. Every other byte is dropped without effect, including 0x2E and the acknowledge byte.
- R3: Seed collection takes exactly 20 bytes. Seed i (i = 0..9) is byte 2i as its low half and byte 2i+1 as its high half. The 20th byte arms the engine for acknowledges.
- R4: Sum A is the modulo-65536 sum of seeds 0..7, which are the set bits of mask 0x00FF.
- R5: Sum B is the modulo-65536 sum of the seeds whose index bit (bits 0..9 only) is set in the configuration word XOR 0x00FF. With the default word 0x021F these are seeds 5, 6, 7 and 9.
- R6: Each byte of a sum is widened and 0x40 is added, giving v. The byte v is emitted as floor(v/2) and then v - floor(v/2). The payload order is: A low byte pair, A high byte pair, B low byte pair, B high byte pair.
- R7: A reply is byte 0x5A followed by the eight payload bytes. One byte moves per cycle in which out_valid and out_ready are both high. While out_ready is low, out_data is held.
- R8: While armed, the first acknowledge byte (default 0x5A) sends a reply and keeps the engine armed. The second sends a reply and returns the engine to idle.
- R9: While armed, bytes other than the acknowledge byte are dropped, lead bytes included.
- R10: Path collection drops bytes until 0x0A arrives and then returns to idle without replying. A 0x56 inside a path does not start seed collection.
- R11: Input bytes offered while a reply is in progress are dropped. This includes the cycle of the reply's final handshake. The byte in the next cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Reply byte available |
| out_data | output | 8 | Reply byte |
| out_ready | input | 1 | Consumer takes the reply byte |

## Verification
Two things can happen in the same cycle: the final handshake of one reply and the arrival of the acknowledge that should start the next. The bench provokes this by holding in_valid high with the acknowledge byte all through the reply, with out_ready high. The correct result is exactly two replies, 18 bytes back to back with a one-cycle gap, and nothing from the third acknowledge, which lands in idle. A behavioural model, compared every clock, judges in which cycle the pending byte is taken.

// File: rtl/seed_resp_pkg.sv
package seed_resp_pkg;

    localparam logic [7:0]  LEAD_SEED = 8'h56;
    localparam logic [7:0]  LEAD_PATH = 8'h44;
    localparam logic [7:0]  PATH_END  = 8'h0A;
    localparam logic [7:0]  REPLY_HDR = 8'h5A;
    localparam logic [8:0]  SUM_BIAS  = 9'h040;
    localparam logic [15:0] MASK_A    = 16'h00FF;

    typedef enum logic [2:0] {
        P_IDLE,
        P_SEED,
        P_PATH,
        P_ARM1,
        P_ARM2
    } parse_st_e;

endpackage

// File: rtl/seed_parser.sv
module seed_parser
    import seed_resp_pkg::*;
#(
    parameter int         NUM_SEEDS = 10,
    parameter int         SEED_W    = 16,
    parameter logic [7:0] ACK_BYTE  = 8'h5A
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic [7:0]                          in_data,
    input  logic                                busy,
    output logic [NUM_SEEDS*SEED_W-1:0]         msg_bytes,
    output logic                                reply_go
);
    localparam int MSG_BYTES = NUM_SEEDS * (SEED_W / 8);
    localparam int CNT_W     = $clog2(MSG_BYTES + 1);

    typedef struct packed {
        parse_st_e                  st;
        logic [CNT_W-1:0]           cnt;
        logic [MSG_BYTES-1:0][7:0]  store;
    } pstate_t;

    pstate_t q, d;
    logic    go_d;

    always_comb begin
        d    = q;
        go_d = 1'b0;
        if (in_valid && !busy) begin
            case (q.st)
                P_IDLE: begin
                    if (in_data == LEAD_SEED) begin
                        d.st  = P_SEED;
                        d.cnt = '0;
                    end else if (in_data == LEAD_PATH) begin
                        d.st = P_PATH;
                    end
                end
                P_SEED: begin
                    d.store[q.cnt] = in_data;
                    if (q.cnt == CNT_W'(MSG_BYTES - 1)) begin
                        d.st  = P_ARM1;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                P_PATH: begin
                    if (in_data == PATH_END) d.st = P_IDLE;
                end
                P_ARM1: begin
                    if (in_data == ACK_BYTE) begin
                        go_d = 1'b1;
                        d.st = P_ARM2;
                    end
                end
                P_ARM2: begin
                    if (in_data == ACK_BYTE) begin
                        go_d = 1'b1;
                        d.st = P_IDLE;
                    end
                end
                default: d.st = P_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= P_IDLE;
            q.cnt   <= '0;
            q.store <= '0;
        end else begin
            q <= d;
        end
    end

    assign msg_bytes = q.store;
    assign reply_go  = go_d;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < CNT_W'(MSG_BYTES)); // R3
    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != P_SEED) |-> (q.cnt == '0)); // R3
    AST_IDLE_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == P_IDLE) |-> !reply_go); // R2
    AST_GO_LEAVES_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        reply_go |=> (q.st == P_ARM2 || q.st == P_IDLE)); // R8
    AST_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(q.st)); // R11

endmodule

// File: rtl/seed_summer.sv
module seed_summer
    import seed_resp_pkg::*;
#(
    parameter int          NUM_SEEDS = 10,
    parameter int          SEED_W    = 16,
    parameter logic [15:0] CFG_WORD  = 16'h021F
) (
    input  logic [NUM_SEEDS*SEED_W-1:0]  msg_bytes,
    output logic [4*SEED_W-1:0]          payload
);
    localparam int          BPS    = SEED_W / 8;
    localparam logic [15:0] MASK_B = CFG_WORD ^ MASK_A;

    logic [NUM_SEEDS-1:0][SEED_W-1:0] seeds;
    logic [1:0][SEED_W-1:0]           sums;

    for (genvar g = 0; g < NUM_SEEDS; g++) begin : g_seed
        assign seeds[g] = msg_bytes[g*SEED_W +: SEED_W];
    end

    always_comb begin
        sums = '0;
        for (int i = 0; i < NUM_SEEDS; i++) begin
            if (MASK_A[i]) sums[0] = sums[0] + seeds[i];
            if (MASK_B[i]) sums[1] = sums[1] + seeds[i];
        end
    end

    for (genvar s = 0; s < 2; s++) begin : g_sum
        for (genvar k = 0; k < BPS; k++) begin : g_byte
            logic [8:0] biased;
            logic [7:0] half;
            logic [7:0] rest;
            assign biased = {1'b0, sums[s][k*8 +: 8]} + SUM_BIAS;
            assign half   = biased[8:1];
            assign rest   = biased[7:0] - half;
            assign payload[((s*BPS + k)*2)*8 +: 8]     = half;
            assign payload[((s*BPS + k)*2 + 1)*8 +: 8] = rest;
        end
    end

endmodule

// File: rtl/reply_seq.sv
module reply_seq
    import seed_resp_pkg::*;
#(
    parameter int PAYLOAD_BYTES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          go,
    input  logic [PAYLOAD_BYTES*8-1:0]    payload,
    input  logic                          out_ready,
    output logic                          out_valid,
    output logic [7:0]                    out_data
);
    localparam int SEL_W = $clog2(PAYLOAD_BYTES);

    typedef struct packed {
        logic             active;
        logic             hdr;
        logic [SEL_W-1:0] sel;
    } rstate_t;

    rstate_t q, d;
    logic [PAYLOAD_BYTES-1:0][7:0] pl;

    assign pl = payload;

    always_comb begin
        d = q;
        if (q.active && out_ready) begin
            if (q.hdr) begin
                d.hdr = 1'b0;
                d.sel = '0;
            end else if (q.sel == SEL_W'(PAYLOAD_BYTES - 1)) begin
                d.active = 1'b0;
            end else begin
                d.sel = q.sel + 1'b1;
            end
        end
        if (go) begin
            d.active = 1'b1;
            d.hdr    = 1'b1;
            d.sel    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.active;
    assign out_data  = q.hdr ? REPLY_HDR : pl[q.sel];

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
    AST_HDR_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_data == REPLY_HDR)); // R7
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        q.active |-> !go); // R11

endmodule

// File: rtl/seed_resp.sv
module seed_resp
    import seed_resp_pkg::*;
#(
    parameter int          NUM_SEEDS = 10,
    parameter int          SEED_W    = 16,
    parameter logic [15:0] CFG_WORD  = 16'h021F,
    parameter logic [7:0]  ACK_BYTE  = 8'h5A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        out_valid,
    output logic [7:0]  out_data,
    input  logic        out_ready
);
    localparam int PAYLOAD_BYTES = 4 * (SEED_W / 8);

    logic [NUM_SEEDS*SEED_W-1:0] msg_bytes;
    logic [PAYLOAD_BYTES*8-1:0]  payload;
    logic                        reply_go;
    logic                        busy;

    assign busy = out_valid;

    seed_parser #(
        .NUM_SEEDS (NUM_SEEDS),
        .SEED_W    (SEED_W),
        .ACK_BYTE  (ACK_BYTE)
    ) u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .busy      (busy),
        .msg_bytes (msg_bytes),
        .reply_go  (reply_go)
    );

    seed_summer #(
        .NUM_SEEDS (NUM_SEEDS),
        .SEED_W    (SEED_W),
        .CFG_WORD  (CFG_WORD)
    ) u_summer (
        .msg_bytes (msg_bytes),
        .payload   (payload)
    );

    reply_seq #(
        .PAYLOAD_BYTES (PAYLOAD_BYTES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (reply_go),
        .payload   (payload),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R1

endmodule

// File: tb/seed_resp_bench.sv
`timescale 1ns/1ps
module seed_resp_bench;
    localparam logic [15:0] CFG = 16'h021F;
    localparam logic [7:0]  ACK = 8'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b1;

    int checks = 0;
    int failures = 0;
    string cur_req = "R7";
    bit rdy_random = 1'b0;
    bit done = 1'b0;

    logic [7:0] got[$];

    // reference model state
    int         m_st;      // 0 idle, 1 seed, 2 path, 3 armed-first, 4 armed-second
    int         m_cnt;
    logic [7:0] m_msg[20];
    logic [7:0] m_frame[9];
    bit         m_active;
    int         m_idx;
    bit         hs, acc;

    seed_resp #(.CFG_WORD(CFG), .ACK_BYTE(ACK)) u_seed_resp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    always #4 clk = ~clk;

    function automatic void build_frame();
        int sa, sb, v, h, sd;
        logic [15:0] mb;
        mb = CFG ^ 16'h00FF;
        sa = 0; sb = 0;
        for (int i = 0; i < 10; i++) begin
            sd = {m_msg[2*i+1], m_msg[2*i]};
            if (i < 8) sa = (sa + sd) % 65536;
            if (mb[i]) sb = (sb + sd) % 65536;
        end
        m_frame[0] = 8'h5A;
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 2; k++) begin
                v = (((s == 0) ? sa : sb) >> (8*k)) % 256 + 64;
                h = v / 2;
                m_frame[1 + s*4 + k*2]     = 8'(h);
                m_frame[1 + s*4 + k*2 + 1] = 8'(v - h);
            end
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_active = 0; m_idx = 0;
        end else begin
            hs  = m_active && out_ready;
            acc = in_valid && !m_active;
            if (hs) begin
                if (m_idx == 8) begin m_active = 0; m_idx = 0; end
                else m_idx++;
            end
            if (acc) begin
                case (m_st)
                    0: if (in_data == 8'h56) begin m_st = 1; m_cnt = 0; end
                       else if (in_data == 8'h44) m_st = 2;
                    1: begin
                        m_msg[m_cnt] = in_data;
                        m_cnt++;
                        if (m_cnt == 20) begin m_st = 3; m_cnt = 0; end
                    end
                    2: if (in_data == 8'h0A) m_st = 0;
                    3, 4: if (in_data == ACK) begin
                        build_frame();
                        m_active = 1; m_idx = 0;
                        m_st = (m_st == 3) ? 4 : 0;
                    end
                    default: m_st = 0;
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                check(out_valid === m_active, cur_req, int'(out_valid), int'(m_active), "out_valid vs model");
                if (m_active)
                    check(out_data === m_frame[m_idx], cur_req, int'(out_data), int'(m_frame[m_idx]), "out_data vs model");
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            out_ready = rdy_random ? 1'($urandom_range(0, 1)) : 1'b1;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && out_valid && out_ready) got.push_back(out_data);
        end
    end

    // called at a negedge
    task automatic send_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_seeds(input logic [15:0] s[10]);
        send_byte(8'h56);
        for (int i = 0; i < 10; i++) begin
            send_byte(s[i][7:0]);
            send_byte(s[i][15:8]);
        end
    endtask

    task automatic drain();
        repeat (2) @(negedge clk);
        while (m_active) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_frame(input logic [7:0] e[9], input string req);
        check(got.size() == 9, req, got.size(), 9, "reply length");
        if (got.size() == 9)
            for (int i = 0; i < 9; i++)
                check(got[i] === e[i], req, int'(got[i]), int'(e[i]), $sformatf("reply byte %0d", i));
        got.delete();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] sd[10];
        logic [7:0]  e[9];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and an early acknowledge
        cur_req = "R1";
        check(out_valid === 1'b0, "R1", int'(out_valid), 0, "out_valid after reset");
        send_byte(ACK);
        drain();
        check(got.size() == 0, "R1", got.size(), 0, "reply to acknowledge before seeds");

        // R2: idle drops 0x2E, acknowledge, others
        cur_req = "R2";
        send_byte(8'h2E); send_byte(8'h11); send_byte(ACK); send_byte(8'hFF);
        drain();
        check(got.size() == 0, "R2", got.size(), 0, "bytes in idle produced output");

        // R3 R4 R5 R6 R7: seeds 1..10, random ready
        cur_req = "R7";
        rdy_random = 1'b1;
        for (int i = 0; i < 10; i++) sd[i] = 16'(i + 1);
        send_seeds(sd);
        // R9: junk while armed
        send_byte(8'h56); send_byte(8'h44); send_byte(8'h0A);
        drain();
        check(got.size() == 0, "R9", got.size(), 0, "non-acknowledge bytes while armed");
        send_byte(ACK);
        drain();
        e = '{8'h5A, 8'h32, 8'h32, 8'h20, 8'h20, 8'h2F, 8'h30, 8'h20, 8'h20};
        check_frame(e, "R3");
        // R8: second acknowledge replies again, third does not
        cur_req = "R8";
        send_byte(ACK);
        drain();
        check_frame(e, "R8");
        send_byte(ACK);
        drain();
        check(got.size() == 0, "R8", got.size(), 0, "third acknowledge replied");

        // R10: path with embedded 0x56 and a full seed-like body
        cur_req = "R10";
        send_byte(8'h44);
        send_seeds(sd);
        send_byte(ACK);
        send_byte(8'h0A);
        send_byte(ACK);
        drain();
        check(got.size() == 0, "R10", got.size(), 0, "path message produced output");

        // R5: seed 8 excluded, seed 9 included
        cur_req = "R5";
        for (int i = 0; i < 10; i++) sd[i] = 16'h0000;
        sd[8] = 16'hBEEF; sd[9] = 16'h0102;
        send_seeds(sd);
        send_byte(ACK);
        drain();
        e = '{8'h5A, 8'h20, 8'h20, 8'h20, 8'h20, 8'h21, 8'h21, 8'h20, 8'h21};
        check_frame(e, "R5");
        send_byte(ACK);
        drain();
        got.delete();

        // R4 R6 R11: wrapping sums, acknowledge held through the replies
        cur_req = "R11";
        rdy_random = 1'b0;
        for (int i = 0; i < 10; i++) sd[i] = 16'hFFFF;
        send_seeds(sd);
        in_valid = 1'b1;
        in_data  = ACK;
        repeat (30) @(negedge clk);
        in_valid = 1'b0;
        drain();
        e = '{8'h5A, 8'h9C, 8'h9C, 8'h9F, 8'hA0, 8'h9E, 8'h9E, 8'h9F, 8'hA0};
        check(got.size() == 18, "R11", got.size(), 18, "bytes from held acknowledge");
        if (got.size() >= 9)
            for (int i = 0; i < 9; i++)
                check(got[i] === e[i], "R4", int'(got[i]), int'(e[i]), $sformatf("wrapped reply byte %0d", i));
        if (got.size() == 18)
            for (int i = 0; i < 9; i++)
                check(got[9+i] === e[i], "R6", int'(got[9+i]), int'(e[i]), $sformatf("second reply byte %0d", i));
        got.delete();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule